// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog that counts a programmed number of coarse time units and flags an expiry. Software sees two byte-wide locations. Offset 0 holds a two-bit time-base select and a sticky expiry flag. Offset 1 holds the count of units. A prescaler divides the system clock down to the selected unit. Each unit tick decrements a down-counter. When the counter runs out, the block sets the flag, emits a one-cycle pulse on `timeout_o`, and stops.

Any write to offset 1 reloads the down-counter and restarts the prescaler. Periodic rewrites of the count therefore act as the kick that keeps the watchdog from firing. Writing zero to offset 1 stops the timer. A strap input chooses the reset defaults. When the strap is high, the block leaves reset already counting ten 1-second units.

Top module: `wdog_timer`

## Requirements
- R1: Bits 7:3 of offset 0 always read as 0, whatever value was written to them.
- R2: The time-base select in offset 0 bits 2:1 sets the unit length: 00 gives CLK_HZ/100 clock cycles, 01 gives CLK_HZ cycles, and 10 gives 60*CLK_HZ cycles.
- R3: Offset 0 bit 0 reads 1 once an expiry has happened. Writing 1 to that bit clears the flag. Writing 0 to it leaves the flag unchanged.
- R4: Suppose a nonzero value N is written to offset 1 on clock edge W. Then `timeout_o` is high in exactly the cycle that follows edge W + N*unit, and the flag reads 1 from that edge onward.
- R5: Writing 0 to offset 1 stops the timer, so no expiry follows. Offset 1 then reads 0.
- R6: If `strap_i` is high during reset, offset 0 resets to 0x02 and offset 1 resets to 0x0A, and the timer counts from reset. If `strap_i` is low, both locations reset to 0x00 and the timer is idle.
- R7: Rewriting offset 1 while the timer runs restarts the full period from the new write. No expiry occurs for the earlier write.
- R8: `timeout_o` is high for exactly one cycle per expiry. After an expiry the timer stays stopped until offset 1 is written again.
- R9: While the select is 11, no unit elapses and the count holds. Choosing a valid select resumes counting.
- R10: Read data appears on `rdata_o` in the cycle after `rd_en_i` is sampled, and it holds when no read is made.
- R11: Offset 1 reads back the last value written, not the remaining count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Selects reset defaults; hold stable while reset is asserted |
| addr_i | input | 1 | Register select: 0 = control/status, 1 = count |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| timeout_o | output | 1 | One-cycle expiry pulse |

## Verification
A wrong prescaler state moves the expiry pulse away from its exact edge, W + N*unit. The bench checks the cycle number of the pulse, so a single-cycle slip is caught on the first expiry. A down-counter that fails to stop, or fails to reload on a kick, shows up as a missing, early or second pulse within one unit of the expected edge. Flag, select and strap-default faults appear on the very next read of offset 0 or offset 1.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    UNIT_10MS = 2'b00,
    UNIT_1S   = 2'b01,
    UNIT_1MIN = 2'b10,
    UNIT_RSVD = 2'b11
  } wdt_unit_e;

  localparam logic [7:0] STRAP_COUNT = 8'h0A;
  localparam logic [1:0] STRAP_UNIT  = 2'b01;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int CLK_HZ = 25_000_000
) (
  input  logic      clk,
  input  logic      srst_n,
  input  logic      run_i,
  input  logic      restart_i,
  input  wdt_unit_e unit_i,
  output logic      tick_o
);
  localparam longint LIM_MIN = 64'(CLK_HZ) * 60;
  localparam int     PW      = $clog2(LIM_MIN + 1);
  localparam logic [PW-1:0] LIM_10MS = PW'(CLK_HZ / 100);
  localparam logic [PW-1:0] LIM_1S   = PW'(CLK_HZ);
  localparam logic [PW-1:0] LIM_1MIN = PW'(LIM_MIN);

  logic [PW-1:0] pre_q, pre_d, limit;
  logic          en;

  always_comb begin
    case (unit_i)
      UNIT_10MS: limit = LIM_10MS;
      UNIT_1S:   limit = LIM_1S;
      UNIT_1MIN: limit = LIM_1MIN;
      default:   limit = LIM_1MIN;
    endcase
    en     = run_i && (unit_i != UNIT_RSVD);
    tick_o = en && !restart_i && (pre_q >= limit - PW'(1));
    if (restart_i)   pre_d = '0;
    else if (!en)    pre_d = pre_q;
    else if (tick_o) pre_d = '0;
    else             pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  a_r9_hold_when_reserved: assert property (@(posedge clk) disable iff (!srst_n)
    (unit_i == UNIT_RSVD && !restart_i) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  logic       strap_i,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       tick_i,
  output logic       run_o,
  output logic       expire_o
);
  logic [7:0] remain_q, remain_d;
  logic       run_q, run_d;

  always_comb begin
    expire_o = tick_i && run_q && !load_i && (remain_q == 8'd1);
    remain_d = remain_q;
    run_d    = run_q;
    if (load_i) begin
      remain_d = load_val_i;
      run_d    = (load_val_i != 8'd0);
    end else if (tick_i && run_q) begin
      remain_d = remain_q - 8'd1;
      if (expire_o) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      remain_q <= strap_i ? STRAP_COUNT : 8'd0;
      run_q    <= strap_i;
    end else begin
      remain_q <= remain_d;
      run_q    <= run_d;
    end
  end

  assign run_o = run_q;

  a_r8_halt_after_expire: assert property (@(posedge clk) disable iff (!srst_n)
    expire_o |=> (!run_q && remain_q == 8'd0));
  a_r5_zero_stops: assert property (@(posedge clk) disable iff (!srst_n)
    (load_i && load_val_i == 8'd0) |=> !run_q);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  logic       strap_i,
  input  logic       addr_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  input  logic       expire_i,
  output wdt_unit_e  unit_o,
  output logic       flag_o,
  output logic       load_o,
  output logic [7:0] load_val_o,
  output logic [7:0] rdata_o
);
  wdt_unit_e  unit_q, unit_d;
  logic       flag_q, flag_d;
  logic [7:0] cnt_q, cnt_d, rdata_q, rdata_d;
  logic       wr_ctl;

  always_comb begin
    wr_ctl = wr_en_i && !addr_i;
    load_o = wr_en_i && addr_i;
    load_val_o = wdata_i;
    unit_d = wr_ctl ? wdt_unit_e'(wdata_i[2:1]) : unit_q;
    cnt_d  = load_o ? wdata_i : cnt_q;
    if (expire_i)                 flag_d = 1'b1;
    else if (wr_ctl && wdata_i[0]) flag_d = 1'b0;
    else                          flag_d = flag_q;
    if (!rd_en_i)    rdata_d = rdata_q;
    else if (addr_i) rdata_d = cnt_q;
    else             rdata_d = {5'b0, unit_q, flag_q};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      unit_q  <= strap_i ? wdt_unit_e'(STRAP_UNIT) : UNIT_10MS;
      cnt_q   <= strap_i ? STRAP_COUNT : 8'd0;
      flag_q  <= 1'b0;
      rdata_q <= 8'd0;
    end else begin
      unit_q  <= unit_d;
      cnt_q   <= cnt_d;
      flag_q  <= flag_d;
      rdata_q <= rdata_d;
    end
  end

  assign unit_o  = unit_q;
  assign flag_o  = flag_q;
  assign rdata_o = rdata_q;

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en_i && !addr_i) |=> (rdata_o[7:3] == 5'b0));
  a_r3_clear_on_one: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_ctl && wdata_i[0] && !expire_i) |=> !flag_q);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int CLK_HZ      = 25_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_i,
  input  logic       addr_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       timeout_o
);
  logic       srst_n, tick, run, expire, flag, load;
  logic [7:0] load_val;
  wdt_unit_e  unit;
  logic       pulse_q;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  wdt_regs u_regs (
    .clk(clk), .srst_n(srst_n), .strap_i(strap_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wdata_i(wdata_i),
    .expire_i(expire), .unit_o(unit), .flag_o(flag), .load_o(load),
    .load_val_o(load_val), .rdata_o(rdata_o));

  wdt_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
    .clk(clk), .srst_n(srst_n), .run_i(run), .restart_i(load),
    .unit_i(unit), .tick_o(tick));

  wdt_counter u_cnt (
    .clk(clk), .srst_n(srst_n), .strap_i(strap_i), .load_i(load),
    .load_val_i(load_val), .tick_i(tick), .run_o(run), .expire_o(expire));

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) pulse_q <= 1'b0;
    else         pulse_q <= expire;
  end

  assign timeout_o = pulse_q;

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    timeout_o |=> !timeout_o);
  a_r3_flag_with_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    timeout_o |-> flag);
  a_r9_no_tick_reserved: assert property (@(posedge clk) disable iff (!srst_n)
    (unit == UNIT_RSVD) |-> !tick);
  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam int HZ = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       timeout;

  int total = 0, bad = 0, cyc = 0, pulse_cnt = 0, last_pc = -1;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  wdog_timer #(.CLK_HZ(HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .addr_i(addr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
    .rdata_o(rdata), .timeout_o(timeout));

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_seen <= rd_en;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // monitor: scoreboard for reads, pulse recorder
  always @(negedge clk) begin
    if (timeout) begin
      pulse_cnt++;
      last_pc = cyc;
    end
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rdata === e, t, int'(rdata), int'(e));
    end
  end

  task automatic do_read(input logic a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic a, input logic [7:0] d, output int w);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 w = cyc;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_pulse(input int tgt, input int base, input string t);
    while (cyc < tgt + 1) @(negedge clk);
    chk(pulse_cnt == base + 1, {t, " pulse count"}, pulse_cnt, base + 1);
    chk(last_pc == tgt, {t, " pulse cycle"}, last_pc, tgt);
    chk(timeout == 1'b0, "R8 pulse width", int'(timeout), 0);
  endtask

  task automatic expect_quiet(input int n, input string t);
    int b = pulse_cnt;
    repeat (n) @(negedge clk);
    chk(pulse_cnt == b, t, pulse_cnt, b);
  endtask

  task automatic do_reset(input logic s, output int rel);
    @(negedge clk);
    strap = s; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rel = cyc;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rel, w, w2, b;
    // R6 strap high defaults
    do_reset(1'b1, rel);
    repeat (4) @(negedge clk);
    do_read(1'b0, 8'h02, "R6 strap ctl default");
    do_read(1'b1, 8'h0A, "R6 strap count default");
    b = pulse_cnt;
    while (pulse_cnt == b && cyc < rel + 10100) @(negedge clk);
    chk(pulse_cnt == b + 1, "R6 strap timer expiry", pulse_cnt, b + 1);
    chk(last_pc >= rel + 9995 && last_pc <= rel + 10010, "R6 strap expiry time",
        last_pc - rel, 10002);
    do_read(1'b0, 8'h03, "R3 flag set");
    do_write(1'b0, 8'h02, w);
    do_read(1'b0, 8'h03, "R3 write zero keeps flag");
    do_write(1'b0, 8'h03, w);
    do_read(1'b0, 8'h02, "R3 write one clears flag");
    expect_quiet(3000, "R8 stopped after expiry");

    // R4 / R2 10 ms unit, count 5
    do_write(1'b0, 8'h00, w);
    b = pulse_cnt;
    do_write(1'b1, 8'd5, w);
    expect_pulse(w + 50, b, "R4 10ms x5");
    do_read(1'b1, 8'd5, "R11 count readback");
    do_read(1'b0, 8'h01, "R4 flag after expiry");

    // R7 kick
    do_write(1'b0, 8'h01, w);
    b = pulse_cnt;
    do_write(1'b1, 8'd5, w);
    repeat (30) @(negedge clk);
    do_write(1'b1, 8'd5, w2);
    expect_pulse(w2 + 50, b, "R7 kick restarts");

    // R5 disable with zero
    do_write(1'b0, 8'h01, w);
    do_write(1'b1, 8'd3, w);
    repeat (10) @(negedge clk);
    do_write(1'b1, 8'd0, w);
    expect_quiet(100, "R5 zero disables");
    do_read(1'b1, 8'd0, "R5 count reads zero");

    // R1 reserved bits, R9 reserved unit
    do_write(1'b0, 8'hFF, w);
    do_read(1'b0, 8'h06, "R1 reserved bits zero");
    b = pulse_cnt;
    do_write(1'b1, 8'd1, w);
    expect_quiet(300, "R9 reserved unit no tick");
    do_write(1'b0, 8'h00, w);
    expect_pulse(w + 10, b, "R9 resume after valid unit");

    // R10 read latency and hold
    do_read(1'b0, 8'h01, "R10 read latency");
    repeat (3) @(negedge clk);
    chk(rdata === 8'h01, "R10 rdata holds", int'(rdata), 1);

    // R2 1 s and 1 min units
    do_write(1'b0, 8'h03, w);
    b = pulse_cnt;
    do_write(1'b1, 8'd2, w);
    expect_pulse(w + 2000, b, "R2 1s unit");
    do_write(1'b0, 8'h05, w);
    b = pulse_cnt;
    do_write(1'b1, 8'd1, w);
    expect_pulse(w + 60000, b, "R2 1min unit");

    // R6 strap low defaults
    do_reset(1'b0, rel);
    repeat (4) @(negedge clk);
    do_read(1'b0, 8'h00, "R6 no-strap ctl default");
    do_read(1'b1, 8'h00, "R6 no-strap count default");
    expect_quiet(1500, "R6 no-strap idle");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule